// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block sits between a processor load/store port and a slower memory port that moves one word per handshake. Each cache line stores a valid flag, a dirty flag, a tag and a block of several words. The processor presents an address and, for a store, a data word. It holds the request unchanged while the cache drives its stall output. A hit is served in the same cycle. Stores that hit change only the cache and mark the line dirty.

On a miss the cache first writes back the victim line if it is dirty, one word per handshake in ascending word order. It then reads the new block from memory. The refill begins with the word the processor asked for and wraps around the block. The processor is released in the cycle that word arrives: a load receives it forwarded from the memory bus, and a store merges its data over it. Stores that miss therefore allocate the line. The rest of the block then streams in while the processor continues. Later accesses that hit other lines are served during this time. Accesses to the line being filled, and further misses, wait until the refill has finished.

Top module: `dm_wb_cache`

## Requirements
- R1: Byte addresses split, from the least significant bit upward, into byte-in-word bits (2 for 32-bit words), word-in-block bits (log2 WORDS), index bits (log2 LINES) and tag bits (the rest). Every memory request carries a word-aligned byte address formed from a tag, the index and a word number in those same positions.
- R2: While reset is held and after its release, no line is valid, memReq is low and cpuStall is low with no request. The first access to any address misses, so cpuStall is high.
- R3: An access whose index holds a valid line with a matching tag completes in its first cycle with cpuStall low and causes no memory traffic. A memory request only starts after a cycle in which the processor was stalled.
- R4: A store that hits updates only the cached word and marks the line dirty. Memory is not written at that time.
- R5: Replacing a dirty line first writes all WORDS words of the old block to memory in ascending word order, and only then issues refill reads. The processor stays stalled during the write-back.
- R6: Replacing a clean line issues no memory writes.
- R7: A store that misses reads the whole block from memory and merges the store word into it. The line is then dirty, its other words hold memory data, and memory keeps the old value until the line is evicted.
- R8: Refill reads start at the missed word and proceed through the higher words to the end of the block, then wrap to word 0.
- R9: The processor is released (cpuStall low) in the cycle the missed word is acknowledged. For a load, cpuRdata equals memRdata in that cycle. The refill continues with memReq still high afterwards.
- R10: While the rest of a block is still refilling, an access that hits a different line is served without stall. An access to the line being filled, or any miss, stalls until the refill has completed.
- R11: Once raised, memReq, memWe, memAddr and (for writes) memWdata stay stable until memAck.
- R12: Every load returns the most recently stored value for its address, across any mix of hits, misses, evictions and refills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cpuReq | input | 1 | Processor access request, held until served |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | ADDR_W | Processor byte address |
| cpuWdata | input | DATA_W | Store data |
| cpuRdata | output | DATA_W | Load data, valid in the cycle the access is served |
| cpuStall | output | 1 | High while the present request cannot be served |
| memReq | output | 1 | Memory word request |
| memWe | output | 1 | 1 = memory write, 0 = memory read |
| memAddr | output | ADDR_W | Word-aligned memory byte address |
| memWdata | output | DATA_W | Write-back data |
| memRdata | input | DATA_W | Read data, valid with memAck |
| memAck | input | 1 | One word transferred in this cycle |

## Verification
The bench builds the cache with 8 lines of 4 words and 16-bit addresses. The tiny index space makes conflict evictions happen every few accesses in the random mix, and a block of four words leaves room for a real wraparound, since a miss on word 2 must read words 2, 3, 0, 1. The bench memory answers each request after 0 to 3 idle cycles. Because of this, the window between the early release and the end of the refill varies, and accesses that overlap a refill are reached for both the same line and other lines.

// File: rtl/dm_cache_pkg.sv
package dm_cache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_EVICT  = 2'd1,
    ST_REFILL = 2'd2
  } cacheState_t;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic captureMiss;  // latch tag/index/word/store flag of the missing access
    logic hitWrite;     // write processor data into a hitting line
    logic beatWrite;    // write one refill word into the line being filled
    logic critBeat;     // the beat carrying the requested word
    logic lineClose;    // refill done: install tag, set valid and dirty
    logic evictSel;     // memory address comes from the victim line
  } ctrlStrobe_t;

endpackage

// File: rtl/dm_cache_dpath.sv
module dm_cache_dpath
  import dm_cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 64,
  parameter int WORDS  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strobe,
  input  logic [$clog2(WORDS)-1:0] wordCnt,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWe,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              cpuHit,
  output logic              victimDirty,
  output logic              sameLine,
  output logic [DATA_W-1:0] cpuRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);

  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int WP_W   = $clog2(WORDS);
  localparam int OFF_W  = WP_W + BYTE_W;
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

  logic [DATA_W-1:0] dataArr [LINES][WORDS];
  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [LINES-1:0]  validArr;
  logic [LINES-1:0]  dirtyArr;

  logic [TAG_W-1:0] cpuTag;
  logic [IDX_W-1:0] cpuIdx;
  logic [WP_W-1:0]  cpuWord;

  logic [TAG_W-1:0] missTag;
  logic [IDX_W-1:0] missIdx;
  logic [WP_W-1:0]  missWord;
  logic             missWe;
  logic [WP_W-1:0]  fillWord;

  assign cpuTag  = cpuAddr[ADDR_W-1 -: TAG_W];
  assign cpuIdx  = cpuAddr[OFF_W +: IDX_W];
  assign cpuWord = cpuAddr[BYTE_W +: WP_W];

  // wraparound order: the counter offset from the requested word
  assign fillWord = missWord + wordCnt;

  assign cpuHit      = validArr[cpuIdx] && (tagArr[cpuIdx] == cpuTag);
  assign victimDirty = validArr[cpuIdx] && dirtyArr[cpuIdx];
  assign sameLine    = (cpuIdx == missIdx);

  assign cpuRdata = strobe.critBeat ? memRdata : dataArr[cpuIdx][cpuWord];
  assign memWdata = dataArr[missIdx][wordCnt];

  always_comb begin
    if (strobe.evictSel)
      memAddr = {tagArr[missIdx], missIdx, wordCnt, {BYTE_W{1'b0}}};
    else
      memAddr = {missTag, missIdx, fillWord, {BYTE_W{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      missTag  <= '0;
      missIdx  <= '0;
      missWord <= '0;
      missWe   <= 1'b0;
    end else if (strobe.captureMiss) begin
      missTag  <= cpuTag;
      missIdx  <= cpuIdx;
      missWord <= cpuWord;
      missWe   <= cpuWe;
    end
  end

  // block storage, no reset needed: reads are gated by the valid flags
  always_ff @(posedge clk) begin
    if (strobe.hitWrite)
      dataArr[cpuIdx][cpuWord] <= cpuWdata;
    if (strobe.beatWrite)
      dataArr[missIdx][fillWord] <= (strobe.critBeat && missWe) ? cpuWdata : memRdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validArr <= '0;
      dirtyArr <= '0;
      for (int i = 0; i < LINES; i++) tagArr[i] <= '0;
    end else begin
      if (strobe.hitWrite)
        dirtyArr[cpuIdx] <= 1'b1;
      if (strobe.lineClose) begin
        validArr[missIdx] <= 1'b1;
        dirtyArr[missIdx] <= missWe;
        tagArr[missIdx]   <= missTag;
      end
    end
  end

endmodule

// File: rtl/dm_cache_ctrl.sv
module dm_cache_ctrl
  import dm_cache_pkg::*;
#(
  parameter int WORDS = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cpuReq,
  input  logic                     cpuWe,
  input  logic                     cpuHit,
  input  logic                     victimDirty,
  input  logic                     sameLine,
  input  logic                     memAck,
  output ctrlStrobe_t              strobe,
  output logic [$clog2(WORDS)-1:0] wordCnt,
  output logic                     memReq,
  output logic                     memWe,
  output logic                     cpuStall
);

  localparam int WP_W = $clog2(WORDS);
  localparam logic [WP_W-1:0] LAST_WORD = WP_W'(WORDS - 1);

  cacheState_t state, nextState;
  logic [WP_W-1:0] nextCnt;

  always_comb begin
    strobe    = '0;
    nextState = state;
    nextCnt   = wordCnt;
    memReq    = 1'b0;
    memWe     = 1'b0;
    cpuStall  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (cpuReq) begin
          if (cpuHit) begin
            strobe.hitWrite = cpuWe;
          end else begin
            cpuStall           = 1'b1;
            strobe.captureMiss = 1'b1;
            nextCnt            = '0;
            nextState          = victimDirty ? ST_EVICT : ST_REFILL;
          end
        end
      end
      ST_EVICT: begin
        memReq          = 1'b1;
        memWe           = 1'b1;
        strobe.evictSel = 1'b1;
        cpuStall        = cpuReq;
        if (memAck) begin
          if (wordCnt == LAST_WORD) begin
            nextCnt   = '0;
            nextState = ST_REFILL;
          end else begin
            nextCnt = wordCnt + 1'b1;
          end
        end
      end
      ST_REFILL: begin
        memReq = 1'b1;
        if (wordCnt == '0) begin
          // requested word: release the processor as it arrives
          strobe.critBeat = memAck;
          cpuStall        = cpuReq && !memAck;
        end else if (cpuReq && cpuHit && !sameLine) begin
          strobe.hitWrite = cpuWe;
        end else begin
          cpuStall = cpuReq;
        end
        if (memAck) begin
          strobe.beatWrite = 1'b1;
          if (wordCnt == LAST_WORD) begin
            strobe.lineClose = 1'b1;
            nextCnt          = '0;
            nextState        = ST_IDLE;
          end else begin
            nextCnt = wordCnt + 1'b1;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      wordCnt <= '0;
    end else begin
      state   <= nextState;
      wordCnt <= nextCnt;
    end
  end

endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache
  import dm_cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 64,
  parameter int WORDS  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuStall,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck
);

  localparam int WP_W = $clog2(WORDS);

  ctrlStrobe_t     strobe;
  logic [WP_W-1:0] wordCnt;
  logic            cpuHit;
  logic            victimDirty;
  logic            sameLine;

  dm_cache_ctrl #(.WORDS(WORDS)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .cpuReq      (cpuReq),
    .cpuWe       (cpuWe),
    .cpuHit      (cpuHit),
    .victimDirty (victimDirty),
    .sameLine    (sameLine),
    .memAck      (memAck),
    .strobe      (strobe),
    .wordCnt     (wordCnt),
    .memReq      (memReq),
    .memWe       (memWe),
    .cpuStall    (cpuStall)
  );

  dm_cache_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LINES  (LINES),
    .WORDS  (WORDS)
  ) u_dpath (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .wordCnt     (wordCnt),
    .cpuAddr     (cpuAddr),
    .cpuWe       (cpuWe),
    .cpuWdata    (cpuWdata),
    .memRdata    (memRdata),
    .cpuHit      (cpuHit),
    .victimDirty (victimDirty),
    .sameLine    (sameLine),
    .cpuRdata    (cpuRdata),
    .memAddr     (memAddr),
    .memWdata    (memWdata)
  );

endmodule

// File: rtl/dm_wb_cache_chk.sv
module dm_wb_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cpuReq,
  input logic              cpuStall,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata
);

  localparam int BYTE_W = $clog2(DATA_W / 8);

  // R11: request fields hold until acknowledged
  p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
    memReq && !memAck |=> memReq && (memWe == $past(memWe)) &&
      (memAddr == $past(memAddr)) && (!memWe || memWdata == $past(memWdata)));

  // R5: processor held off while the victim is written back
  p_evict_stall_r5: assert property (@(posedge clk) disable iff (rst)
    cpuReq && memReq && memWe |-> cpuStall);

  // R5: once refill reads have begun, no write-back follows in the same miss
  p_no_write_after_read_r5: assert property (@(posedge clk) disable iff (rst)
    memReq && !memWe && memAck |=> !(memReq && memWe));

  // R3: memory traffic only starts after a stalled processor cycle
  p_traffic_after_miss_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(memReq) |-> $past(cpuReq && cpuStall));

  // R1: memory addresses are word aligned
  p_word_align_r1: assert property (@(posedge clk) disable iff (rst)
    memReq |-> (memAddr[BYTE_W-1:0] == '0));

endmodule

bind dm_wb_cache dm_wb_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_dm_wb_cache.sv
module tb_dm_wb_cache;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int LINES  = 8;
  localparam int WORDS  = 4;
  localparam int MEMW   = 1024;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cpuReq = 1'b0;
  logic              cpuWe = 1'b0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic [DATA_W-1:0] cpuWdata = '0;
  logic [DATA_W-1:0] cpuRdata;
  logic              cpuStall;
  logic              memReq;
  logic              memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWdata;
  logic [DATA_W-1:0] memRdata = '0;
  logic              memAck = 1'b0;

  always #4 clk = ~clk;

  dm_wb_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS)) dut (.*);

  logic [31:0] mem    [0:MEMW-1];
  logic [31:0] refMem [0:MEMW-1];
  logic        mValid [0:LINES-1];
  logic [8:0]  mTag   [0:LINES-1];

  int checks = 0;
  int fails  = 0;
  int rdN = 0;
  int wrN = 0;
  int rdLog [0:15];
  int rdStamp [0:15];
  int wrLog [0:15];
  int waitCnt = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // memory model: answers at negedge + 1 after 0..3 idle cycles
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (!rst && memReq) begin
        if (waitCnt == 0) begin
          memAck = 1'b1;
          if (memWe) begin
            mem[memAddr[11:2]] = memWdata;
            wrLog[wrN % 16] = int'(memAddr[11:2]);
            wrN++;
          end else begin
            memRdata = mem[memAddr[11:2]];
            rdLog[rdN % 16] = int'(memAddr[11:2]);
            rdStamp[rdN % 16] = wrN;
            rdN++;
          end
          waitCnt = $urandom_range(0, 3);
        end else begin
          memAck = 1'b0;
          waitCnt--;
        end
      end else begin
        memAck = 1'b0;
      end
    end
  end

  function automatic bit predHit(input logic [15:0] a);
    return mValid[a[6:4]] && (mTag[a[6:4]] == a[15:7]);
  endfunction

  // one processor access; reports stall cycles and memReq at the first sample
  task automatic access(input logic we, input logic [15:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int stalls, output logic reqAtStart);
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = a; cpuWdata = wd;
    stalls = 0;
    #2;
    reqAtStart = memReq;
    while (cpuStall) begin
      stalls++;
      @(negedge clk);
      #2;
    end
    rd = cpuRdata;
    if (!predHit(a)) begin
      mValid[a[6:4]] = 1'b1;
      mTag[a[6:4]] = a[15:7];
    end
    if (we) refMem[a[11:2]] = wd;
  endtask

  task automatic idleUntilQuiet();
    @(negedge clk);
    cpuReq = 1'b0;
    #3;
    while (memReq) begin
      @(negedge clk);
      #3;
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      check(1'b0, "watchdog", 32'd0, 32'd1);
      finishRun();
    end
  end

  initial begin
    logic [31:0] rd;
    int st;
    logic rq;
    int r0, w0;
    void'($urandom(32'd1234));
    for (int i = 0; i < MEMW; i++) begin
      mem[i] = (i * 32'h9E3779B1) ^ 32'h5A5A0000;
      refMem[i] = mem[i];
    end
    for (int i = 0; i < LINES; i++) begin
      mValid[i] = 1'b0;
      mTag[i] = '0;
    end

    // R2: reset state
    repeat (3) @(negedge clk);
    #2;
    check(!cpuStall && !memReq, "R2 reset outputs", {30'd0, cpuStall, memReq}, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // R2 R8 R9: cold miss on word 2 of line 0
    r0 = rdN;
    access(1'b0, 16'h0008, 32'd0, rd, st, rq);
    check(st > 0, "R2 first access misses", st, 32'd1);
    check(rd == refMem[2], "R9 forwarded word", rd, refMem[2]);
    check(memAck == 1'b1, "R9 release on critical ack", {31'd0, memAck}, 32'd1);
    @(negedge clk);
    cpuReq = 1'b0;
    #3;
    check(memReq && !memWe, "R9 refill continues after release", {30'd0, memReq, memWe}, 32'd2);
    idleUntilQuiet();
    check(rdN - r0 == 4, "R8 four refill reads", rdN - r0, 32'd4);
    check(rdLog[r0 % 16] == 2 && rdLog[(r0 + 1) % 16] == 3 &&
          rdLog[(r0 + 2) % 16] == 0 && rdLog[(r0 + 3) % 16] == 1,
          "R8 wrap order 2,3,0,1", rdLog[(r0 + 2) % 16], 32'd0);

    // R3: hit on another word of the same line
    r0 = rdN;
    access(1'b0, 16'h0004, 32'd0, rd, st, rq);
    check(st == 0, "R3 hit no stall", st, 32'd0);
    check(rd == refMem[1], "R3 hit data", rd, refMem[1]);
    idleUntilQuiet();
    check(rdN == r0, "R3 no traffic on hit", rdN - r0, 32'd0);

    // R4: write hit stays in cache
    w0 = wrN;
    access(1'b1, 16'h0004, 32'hCAFE0001, rd, st, rq);
    check(st == 0, "R4 write hit no stall", st, 32'd0);
    idleUntilQuiet();
    check(mem[1] != 32'hCAFE0001 && wrN == w0, "R4 memory untouched", mem[1], 32'd0);
    access(1'b0, 16'h0004, 32'd0, rd, st, rq);
    check(rd == 32'hCAFE0001, "R4 read back", rd, 32'hCAFE0001);

    // R1 R5: dirty line 0 replaced by tag 1 index 0
    w0 = wrN; r0 = rdN;
    access(1'b0, 16'h0084, 32'd0, rd, st, rq);
    check(rd == refMem[33], "R5 new line data", rd, refMem[33]);
    idleUntilQuiet();
    check(wrN - w0 == 4, "R5 whole block written back", wrN - w0, 32'd4);
    check(wrLog[w0 % 16] == 0 && wrLog[(w0 + 1) % 16] == 1 &&
          wrLog[(w0 + 2) % 16] == 2 && wrLog[(w0 + 3) % 16] == 3,
          "R1 write-back addresses old tag", wrLog[(w0 + 3) % 16], 32'd3);
    check(mem[1] == 32'hCAFE0001, "R5 dirty word reached memory", mem[1], 32'hCAFE0001);
    check(rdStamp[r0 % 16] == w0 + 4, "R5 reads after write-back", rdStamp[r0 % 16], w0 + 4);
    check(rdLog[r0 % 16] == 33, "R1 refill address", rdLog[r0 % 16], 32'd33);

    // R6: clean victim replaced
    w0 = wrN;
    access(1'b0, 16'h0104, 32'd0, rd, st, rq);
    idleUntilQuiet();
    check(wrN == w0, "R6 no write-back for clean line", wrN - w0, 32'd0);
    check(rd == refMem[65], "R6 data", rd, refMem[65]);

    // R7: write miss allocates
    r0 = rdN;
    access(1'b1, 16'h0028, 32'hBEEF0007, rd, st, rq);
    check(st > 0, "R7 write miss stalls", st, 32'd1);
    idleUntilQuiet();
    check(rdN - r0 == 4, "R7 block fetched", rdN - r0, 32'd4);
    access(1'b0, 16'h0020, 32'd0, rd, st, rq);
    check(st == 0 && rd == refMem[8], "R7 other word from memory", rd, refMem[8]);
    access(1'b0, 16'h0028, 32'd0, rd, st, rq);
    check(st == 0 && rd == 32'hBEEF0007, "R7 merged store", rd, 32'hBEEF0007);
    check(mem[10] != 32'hBEEF0007, "R7 memory keeps old value", mem[10], 32'd0);
    access(1'b0, 16'h00A8, 32'd0, rd, st, rq);
    idleUntilQuiet();
    check(mem[10] == 32'hBEEF0007, "R7 line was dirty", mem[10], 32'hBEEF0007);

    // R10: overlap with an unfinished refill
    access(1'b0, 16'h0034, 32'd0, rd, st, rq);
    check(rd == refMem[13], "R10 miss data", rd, refMem[13]);
    access(1'b0, 16'h0104, 32'd0, rd, st, rq);
    check(st == 0 && rq == 1'b1, "R10 other-line hit during refill", {st[30:0], rq}, 32'd1);
    check(rd == refMem[65], "R10 hit data during refill", rd, refMem[65]);
    access(1'b0, 16'h0030, 32'd0, rd, st, rq);
    if (rq) check(st > 0, "R10 same line waits", st, 32'd1);
    check(!memReq && rd == refMem[12], "R10 served after refill", rd, refMem[12]);
    idleUntilQuiet();

    // R12 R3 R10: random mix
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      logic we;
      logic [31:0] wd;
      bit hitExp;
      bit stallExp;
      logic [31:0] expRd;
      a = {7'd0, 2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), 2'b00};
      we = ($urandom_range(0, 2) == 0);
      wd = $urandom;
      hitExp = predHit(a);
      expRd = refMem[a[11:2]];
      access(we, a, wd, rd, st, rq);
      stallExp = !hitExp || (rq && (a[6:4] == dut.u_dpath.missIdx));
      if (!we) check(rd == expRd, "R12 load value", rd, expRd);
      if (!rq) check((st > 0) == stallExp, "R3 hit/miss stall", st, {31'd0, stallExp});
      if ($urandom_range(0, 3) == 0) idleUntilQuiet();
    end
    idleUntilQuiet();

    done = 1;
    finishRun();
  end

endmodule